// File: doc/BRIEF.md
# Card Clock-Select Control Register

This block is a 32-bit control register for a card host controller. It holds three 3-bit clock-timing fields: the receive sample phase, the transmit drive phase and a divider value. It also holds one sticky wake-interrupt status bit. Software reads the register whole and writes it whole. A hardware wake event sets the status bit, and software clears it by writing a one back to it, so a read-modify-write of the register clears a pending wake as a side effect.

The block keeps two built-in timing presets, one for single-data-rate bus operation and one for double-data-rate bus operation. When the bus-mode input changes, the matching preset is copied into the three timing fields on the next clock edge. The block also passes the host's outgoing command word through. Whenever the drive-phase field is nonzero, it forces the hold-register-use bit in that word to one.

Top module: `clksel_ctl`

## Requirements
- R1: A register write stores sample phase from write bits 2:0, drive phase from bits 18:16 and divider from bits 26:24, and the read port returns them at the same positions on the cycle after the write. A write that changes only the sample field therefore leaves the other two fields intact.
- R2: Every read bit other than 2:0, 11, 18:16 and 26:24 reads as zero, and writes to those bits have no effect.
- R3: A cycle with the wake-event input high sets read bit 11 on the next cycle. The bit then stays set until it is cleared.
- R4: A write with bit 11 = 1 clears the wake flag on the next cycle. A write with bit 11 = 0 leaves the flag unchanged.
- R5: When a wake event and a clearing write arrive in the same cycle, the flag is set afterwards.
- R6: The interrupt output equals the wake flag ANDed with the interrupt-enable input.
- R7: While the drive-phase field is nonzero, the command output equals the command input with bit 29 forced to 1. While the field is zero, the command output equals the command input.
- R8: When the mode input (1 = double data rate, 0 = single data rate) differs from the mode the block last registered, the next clock edge loads the matching preset into the three fields. A mode held steady causes no reload.
- R9: A register write in the same cycle as a mode change wins. The written fields are stored, and the mode change counts as taken, so no preset is loaded later.
- R10: After reset the fields hold the single-data-rate preset, the wake flag is clear and the registered mode is single data rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Register write value |
| reg_rd_data | output | 32 | Current register value |
| wake_evt | input | 1 | Hardware wake event, sets the sticky flag |
| wake_irq_en | input | 1 | Interrupt enable |
| wake_irq | output | 1 | Wake interrupt |
| ddr_mode | input | 1 | Bus mode: 1 double data rate, 0 single data rate |
| cmd_in | input | 32 | Outgoing command word from the host |
| cmd_out | output | 32 | Command word with the hold bit merged in |

## Verification
Two situations are hard to reach from the ports: a clearing write that lands in the same cycle as a wake event, and a register write that lands in the same cycle as a mode toggle. With random stimulus both coincide only rarely. The bench therefore drives each coincidence directly, and it also runs a long random phase in which writes, wake pulses and mode toggles overlap freely. A reference model in the bench tracks the register cycle by cycle so that every one of those overlaps is checked.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
    localparam int REG_W    = 32;
    localparam int FLD_W    = 3;
    localparam int SMPL_LSB = 0;
    localparam int DRV_LSB  = 16;
    localparam int DIV_LSB  = 24;
    localparam int WAKE_BIT = 11;
    localparam int HOLD_BIT = 29;

    typedef struct packed {
        logic [FLD_W-1:0] div;
        logic [FLD_W-1:0] drv;
        logic [FLD_W-1:0] smpl;
    } phase_cfg_t;

    function automatic phase_cfg_t unpack_cfg(input logic [REG_W-1:0] w);
        phase_cfg_t c;
        c.smpl = w[SMPL_LSB +: FLD_W];
        c.drv  = w[DRV_LSB  +: FLD_W];
        c.div  = w[DIV_LSB  +: FLD_W];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_cfg(input phase_cfg_t c, input logic wake);
        logic [REG_W-1:0] w;
        w = '0;
        w[SMPL_LSB +: FLD_W] = c.smpl;
        w[DRV_LSB  +: FLD_W] = c.drv;
        w[DIV_LSB  +: FLD_W] = c.div;
        w[WAKE_BIT]          = wake;
        return w;
    endfunction
endpackage

// File: rtl/clksel_phase_reg.sv
module clksel_phase_reg #(
    parameter clksel_pkg::phase_cfg_t SDR_CFG = '0,
    parameter clksel_pkg::phase_cfg_t DDR_CFG = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  clksel_pkg::phase_cfg_t wr_cfg,
    input  logic                   ddr_mode,
    output clksel_pkg::phase_cfg_t cfg,
    output logic                   mode_seen
);
    typedef struct packed {
        clksel_pkg::phase_cfg_t cfg;
        logic                   ddr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.cfg = wr_cfg;
        end else if (ddr_mode != st_q.ddr) begin
            st_d.cfg = ddr_mode ? DDR_CFG : SDR_CFG;
        end
        st_d.ddr = ddr_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg <= SDR_CFG;
            st_q.ddr <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg       = st_q.cfg;
    assign mode_seen = st_q.ddr;
endmodule

// File: rtl/clksel_wake_flag.sv
module clksel_wake_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    typedef struct packed {
        logic flag;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_req) begin
            st_d.flag = 1'b0;
        end
        if (set_evt) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
    assign irq  = st_q.flag & irq_en;
endmodule

// File: rtl/clksel_cmd_hold.sv
module clksel_cmd_hold #(
    parameter int CMD_W    = 32,
    parameter int HOLD_BIT = 29,
    parameter int DRV_W    = 3
) (
    input  logic [CMD_W-1:0] cmd_in,
    input  logic [DRV_W-1:0] drv,
    output logic [CMD_W-1:0] cmd_out
);
    logic use_hold;

    always_comb begin
        use_hold = |drv;
        cmd_out  = cmd_in;
        if (use_hold) begin
            cmd_out[HOLD_BIT] = 1'b1;
        end
    end
endmodule

// File: rtl/clksel_ctl.sv
module clksel_ctl #(
    parameter int SDR_SMPL = 2,
    parameter int SDR_DRV  = 0,
    parameter int SDR_DIV  = 1,
    parameter int DDR_SMPL = 3,
    parameter int DDR_DRV  = 2,
    parameter int DDR_DIV  = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [31:0] reg_wr_data,
    output logic [31:0] reg_rd_data,
    input  logic        wake_evt,
    input  logic        wake_irq_en,
    output logic        wake_irq,
    input  logic        ddr_mode,
    input  logic [31:0] cmd_in,
    output logic [31:0] cmd_out
);
    import clksel_pkg::*;

    localparam phase_cfg_t SDR_CFG = '{div: FLD_W'(SDR_DIV), drv: FLD_W'(SDR_DRV), smpl: FLD_W'(SDR_SMPL)};
    localparam phase_cfg_t DDR_CFG = '{div: FLD_W'(DDR_DIV), drv: FLD_W'(DDR_DRV), smpl: FLD_W'(DDR_SMPL)};

    phase_cfg_t wr_cfg;
    phase_cfg_t cfg_q;
    logic       mode_q;
    logic       wake_q;
    logic       clr_req;

    assign wr_cfg  = unpack_cfg(reg_wr_data);
    assign clr_req = reg_wr_en & reg_wr_data[WAKE_BIT];

    clksel_phase_reg #(
        .SDR_CFG (SDR_CFG),
        .DDR_CFG (DDR_CFG)
    ) phase_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_cfg    (wr_cfg),
        .ddr_mode  (ddr_mode),
        .cfg       (cfg_q),
        .mode_seen (mode_q)
    );

    clksel_wake_flag wake_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (wake_evt),
        .clr_req (clr_req),
        .irq_en  (wake_irq_en),
        .flag    (wake_q),
        .irq     (wake_irq)
    );

    clksel_cmd_hold #(
        .CMD_W    (REG_W),
        .HOLD_BIT (HOLD_BIT),
        .DRV_W    (FLD_W)
    ) hold_i (
        .cmd_in  (cmd_in),
        .drv     (cfg_q.drv),
        .cmd_out (cmd_out)
    );

    assign reg_rd_data = pack_cfg(cfg_q, wake_q);
endmodule

// File: rtl/clksel_ctl_chk.sv
module clksel_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_en,
    input logic [31:0] reg_wr_data,
    input logic [31:0] reg_rd_data,
    input logic        wake_evt,
    input logic        wake_irq_en,
    input logic        wake_irq,
    input logic        ddr_mode,
    input logic        mode_q,
    input logic [31:0] cmd_in,
    input logic [31:0] cmd_out
);
    localparam logic [31:0] FLD_MASK  = 32'h0707_0007;
    localparam logic [31:0] USED_MASK = 32'h0707_0807;

    // R1
    wr_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> ((reg_rd_data & FLD_MASK) == ($past(reg_wr_data) & FLD_MASK)));

    // R2
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data & ~USED_MASK) == 32'h0);

    // R3
    wake_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> reg_rd_data[11]);

    // R3
    wake_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_evt && !reg_rd_data[11]) |=> !reg_rd_data[11]);

    // R4
    wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data[11] && !(reg_wr_en && reg_wr_data[11])) |=> reg_rd_data[11]);

    // R4
    wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wr_data[11] && !wake_evt) |=> !reg_rd_data[11]);

    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq == (reg_rd_data[11] && wake_irq_en));

    // R7
    hold_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data[18:16] != 3'd0) |-> (cmd_out == (cmd_in | 32'h2000_0000)));

    // R7
    hold_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data[18:16] == 3'd0) |-> (cmd_out == cmd_in));

    // R8
    fields_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr_en && ddr_mode == mode_q) |=> $stable(reg_rd_data & FLD_MASK));

    // R9
    mode_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mode_q == $past(ddr_mode)));
endmodule

bind clksel_ctl clksel_ctl_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .reg_rd_data (reg_rd_data),
    .wake_evt    (wake_evt),
    .wake_irq_en (wake_irq_en),
    .wake_irq    (wake_irq),
    .ddr_mode    (ddr_mode),
    .mode_q      (mode_q),
    .cmd_in      (cmd_in),
    .cmd_out     (cmd_out)
);

// File: tb/clksel_ctl_tb.sv
module clksel_ctl_tb_top;
    localparam int SS = 2, SD = 0, SV = 1;
    localparam int DS = 3, DD = 2, DV = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        wake_evt = 1'b0;
    logic        wake_irq_en = 1'b0;
    logic        wake_irq;
    logic        ddr_mode = 1'b0;
    logic [31:0] cmd_in = '0;
    logic [31:0] cmd_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [2:0] m_smpl, m_drv, m_div;
    logic       m_flag, m_mode;

    always #5ns clk = ~clk;

    clksel_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .wake_evt(wake_evt), .wake_irq_en(wake_irq_en),
        .wake_irq(wake_irq), .ddr_mode(ddr_mode), .cmd_in(cmd_in), .cmd_out(cmd_out)
    );

    function automatic logic [31:0] word(input logic [2:0] s, input logic [2:0] d,
                                         input logic [2:0] v, input logic f);
        return {5'd0, v, 5'd0, d, 4'd0, f, 8'd0, s};
    endfunction

    function automatic logic [31:0] exp_cmd(input logic [31:0] c, input logic [2:0] d);
        return (d != 3'd0) ? (c | 32'h2000_0000) : c;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic we, input logic [31:0] wd, input logic wk,
                       input logic md, input logic en, input logic [31:0] ci);
        @(negedge clk);
        reg_wr_en = we; reg_wr_data = wd; wake_evt = wk;
        ddr_mode = md; wake_irq_en = en; cmd_in = ci;
        @(posedge clk);
        if (we) begin
            m_smpl = wd[2:0]; m_drv = wd[18:16]; m_div = wd[26:24];
        end else if (md != m_mode) begin
            m_smpl = md ? 3'(DS) : 3'(SS);
            m_drv  = md ? 3'(DD) : 3'(SD);
            m_div  = md ? 3'(DV) : 3'(SV);
        end
        m_mode = md;
        m_flag = (m_flag & ~(we & wd[11])) | wk;
        #1;
        chk("R1/R2/R4/R8/R9 register", reg_rd_data, word(m_smpl, m_drv, m_div, m_flag));
        chk("R6 irq", {31'd0, wake_irq}, {31'd0, m_flag & en});
        chk("R7 cmd", cmd_out, exp_cmd(ci, m_drv));
    endtask

    initial begin
        m_smpl = 3'(SS); m_drv = 3'(SD); m_div = 3'(SV); m_flag = 1'b0; m_mode = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        chk("R10 reset", reg_rd_data, 32'h0100_0002);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(0, 0, 0, 0, 0, 32'h1234_5678);
        // R10 still SDR preset, R7 pass-through with drive 0
        chk("R10 idle", reg_rd_data, 32'h0100_0002);
        chk("R7 pass", cmd_out, 32'h1234_5678);
        // R2 all-ones write
        cyc(1, 32'hFFFF_FFFF, 0, 0, 0, 32'h0);
        chk("R2 ones", reg_rd_data, 32'h0707_0007);
        chk("R7 force", cmd_out, 32'h2000_0000);
        // R1 sample-only rewrite keeps others
        cyc(1, 32'h0707_0005, 0, 0, 0, 32'h0);
        chk("R1 rmw", reg_rd_data, 32'h0707_0005);
        // R3 wake sets, R6 irq gating
        cyc(0, 0, 1, 0, 0, 32'h0);
        chk("R3 set", reg_rd_data, 32'h0707_0805);
        chk("R6 masked", {31'd0, wake_irq}, 32'd0);
        cyc(0, 0, 0, 0, 1, 32'h0);
        chk("R3 sticky", reg_rd_data, 32'h0707_0805);
        chk("R6 enabled", {31'd0, wake_irq}, 32'd1);
        // R4 write zero to bit 11 keeps flag
        cyc(1, 32'h0000_0001, 0, 0, 1, 32'hA5A5_A5A5);
        chk("R4 keep", reg_rd_data, 32'h0000_0801);
        chk("R7 drive0", cmd_out, 32'hA5A5_A5A5);
        // R4 write one clears
        cyc(1, 32'h0000_0801, 0, 0, 1, 32'h0);
        chk("R4 clear", reg_rd_data, 32'h0000_0001);
        // R5 wake and clear together
        cyc(0, 0, 1, 0, 1, 32'h0);
        cyc(1, 32'h0000_0801, 1, 0, 1, 32'h0);
        chk("R5 both", reg_rd_data, 32'h0000_0801);
        cyc(1, 32'h0000_0800, 0, 0, 1, 32'h0);
        // R8 switch to DDR loads DDR preset
        cyc(0, 0, 0, 1, 0, 32'h0);
        chk("R8 ddr", reg_rd_data, 32'h0102_0003);
        chk("R7 ddr force", cmd_out, 32'h2000_0000);
        // R8 steady mode, software write persists
        cyc(1, 32'h0004_0006, 0, 1, 0, 32'h0);
        cyc(0, 0, 0, 1, 0, 32'h0);
        chk("R8 no reload", reg_rd_data, 32'h0004_0006);
        // R8 back to SDR
        cyc(0, 0, 0, 0, 0, 32'h0);
        chk("R8 sdr", reg_rd_data, 32'h0100_0002);
        // R9 write with mode change wins, no later load
        cyc(1, 32'h0305_0004, 0, 1, 0, 32'h0);
        chk("R9 write wins", reg_rd_data, 32'h0305_0004);
        cyc(0, 0, 0, 1, 0, 32'h0);
        chk("R9 consumed", reg_rd_data, 32'h0305_0004);
        // random phase, fixed seed
        void'($urandom(32'd24680));
        for (int i = 0; i < 3000; i++) begin
            logic we, wk, md, en;
            logic [31:0] wd;
            we = ($urandom % 4) == 0;
            wk = ($urandom % 8) == 0;
            md = (($urandom % 12) == 0) ? ~m_mode : m_mode;
            en = $urandom % 2;
            wd = $urandom;
            cyc(we, wd, wk, md, en, $urandom);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule